// File: doc/BRIEF.md
# Highway-Priority Signal Controller with Pedestrian Phase

This block sequences the signals at a crossing where a heavily used east-west highway meets a quiet north-south side road. The highway shows green unless there is a request. A request is either a vehicle reported by a presence sensor on the side road or a press of a walk button. Once a request is seen, the highway stays green for a fixed minimum. The controller then gives either a walk phase, in which both roads are red, or a side-road green. All phase lengths are fixed counts of clock cycles. There is no amber phase: each road switches straight between green and red.

A walk request is stored once it is seen, so a short press is not lost. After that, the button is locked out until a full vehicle green has run in one direction or the other. The request is the highest priority in the controller. Even so, a button held down all the time cannot keep traffic from moving. The sensor and the button both pass through a two-stage synchronizer before the controller uses them.

Top module: `hwySignalCtl`

## Requirements
- R1: While synchronous reset is high, and on the cycle after it, the highway shows green, the side road shows red and the walk indication is off. The stored walk request and the lockout are cleared.
- R2: While the side-road sensor is low and no walk request is stored, the highway stays green indefinitely.
- R3: Each input passes through two synchronizer stages, and the controller then spends one more clock edge deciding to act. If the sensor is first sampled high at clock edge k, the highway is green after edges k through k+7 and red after edge k+8. This gives 6 cycles of highway green after the decision.
- R4: A side-road green lasts exactly 4 cycles. The highway is then green again.
- R5: A walk phase lasts exactly 3 cycles, with both roads red and the walk indication on.
- R6: A walk-button press of a single cycle is stored. The stored request adds one clock edge of delay compared with the sensor path, so the highway turns red after edge k+9 when the press is first sampled at edge k.
- R7: A button press made while a request is stored, or while the lockout is active, has no effect. The lockout begins when a walk phase starts and ends when the next vehicle green completes.
- R8: If a stored walk request and an active sensor are both present when the highway minimum expires, the walk phase runs first. If the sensor is still active when the walk ends, the side-road green follows directly.
- R9: After every walk phase a full vehicle green follows before another walk can begin. This is the side-road green if the sensor is active. Otherwise it is a 6-cycle highway green. With the sensor and the button held high together, side-road greens and walk phases alternate.
- R10: In every cycle exactly one of highway green, side green and walk is on. Each red output is the inverse of the green output for the same road.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sideCar | input | 1 | Side-road vehicle presence sensor, asynchronous |
| walkBtn | input | 1 | Pedestrian walk button, asynchronous |
| hwyGreen | output | 1 | Highway green |
| hwyRed | output | 1 | Highway red |
| sideGreen | output | 1 | Side-road green |
| sideRed | output | 1 | Side-road red |
| walkOn | output | 1 | Pedestrian walk indication |

## Verification
The hardest case to reach from the ports is a button press that lands inside the lockout window. The press must be seen by the synchronizer during a walk phase, or during the highway green that follows it, and must be released before the lockout ends. Random pulses seldom line up with that window. The stimulus therefore waits for the walk indication to rise and pulses the button at fixed offsets from that point. It then watches that no second walk ever appears. A held button combined with a held sensor drives the alternation case. Random sensor and button traffic is compared against a cycle-level reference model kept in the bench.

// File: rtl/sigPkg.sv
package sigPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SIDE,
    ST_WALK
  } phase_e;

  typedef enum logic [1:0] {
    T_HOLD,
    T_SIDE,
    T_WALK
  } tSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  load;      // load the phase timer
    tSel_e sel;       // which length to load
    logic  consume;   // walk phase starting: drop request, arm lockout
    logic  flowDone;  // a vehicle green finished: release lockout
  } strobe_t;

endpackage

// File: rtl/sigDatapath.sv
module sigDatapath
  import sigPkg::*;
#(
  parameter int HOLD_CYC    = 6,
  parameter int SIDE_CYC    = 4,
  parameter int WALK_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    sideCar,
  input  logic    walkBtn,
  input  strobe_t stb,
  output logic    carSync,
  output logic    walkReq,
  output logic    timerZero
);

  localparam int MAXA = (HOLD_CYC > SIDE_CYC) ? HOLD_CYC : SIDE_CYC;
  localparam int MAXC = (MAXA > WALK_CYC) ? MAXA : WALK_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int NIN  = 2;

  logic [NIN-1:0] rawIn;
  logic [NIN-1:0] syncOut;
  logic           btnSync;
  logic           lockOut;
  logic [TW-1:0]  tmr;
  logic [TW-1:0]  loadVal;

  assign rawIn = {walkBtn, sideCar};

  // one synchronizer chain per asynchronous input
  for (genvar g = 0; g < NIN; g++) begin : gSync
    logic [SYNC_STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = sh[SYNC_STAGES-1];
  end

  assign carSync = syncOut[0];
  assign btnSync = syncOut[1];

  // request latch: set on a level while open, dropped when the walk starts
  always_ff @(posedge clk) begin
    if (rst)              walkReq <= 1'b0;
    else if (stb.consume) walkReq <= 1'b0;
    else if (btnSync && !lockOut) walkReq <= 1'b1;
  end

  // lockout: arming wins over release on the same edge
  always_ff @(posedge clk) begin
    if (rst)               lockOut <= 1'b0;
    else if (stb.consume)  lockOut <= 1'b1;
    else if (stb.flowDone) lockOut <= 1'b0;
  end

  always_comb begin
    unique case (stb.sel)
      T_SIDE:  loadVal = TW'(SIDE_CYC - 1);
      T_WALK:  loadVal = TW'(WALK_CYC - 1);
      default: loadVal = TW'(HOLD_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           tmr <= '0;
    else if (stb.load) tmr <= loadVal;
    else if (tmr != '0) tmr <= tmr - 1'b1;
  end

  assign timerZero = (tmr == '0);

endmodule

// File: rtl/sigControl.sv
module sigControl
  import sigPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    carSync,
  input  logic    walkReq,
  input  logic    timerZero,
  output strobe_t stb,
  output logic    hwyGreen,
  output logic    sideGreen,
  output logic    walkOn
);

  phase_e st, nxt;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  always_comb begin
    nxt = st;
    stb = '0;
    unique case (st)
      ST_IDLE: begin
        if (carSync || walkReq) begin
          nxt      = ST_HOLD;
          stb.load = 1'b1;
          stb.sel  = T_HOLD;
        end
      end
      ST_HOLD: begin
        if (timerZero) begin
          stb.flowDone = 1'b1;
          if (walkReq) begin
            nxt         = ST_WALK;
            stb.load    = 1'b1;
            stb.sel     = T_WALK;
            stb.consume = 1'b1;
          end else if (carSync) begin
            nxt      = ST_SIDE;
            stb.load = 1'b1;
            stb.sel  = T_SIDE;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_SIDE: begin
        if (timerZero) begin
          stb.flowDone = 1'b1;
          nxt          = ST_IDLE;
        end
      end
      default: begin
        if (timerZero) begin
          stb.load = 1'b1;
          if (carSync) begin
            nxt     = ST_SIDE;
            stb.sel = T_SIDE;
          end else begin
            nxt     = ST_HOLD;
            stb.sel = T_HOLD;
          end
        end
      end
    endcase
  end

  assign hwyGreen  = (st == ST_IDLE) || (st == ST_HOLD);
  assign sideGreen = (st == ST_SIDE);
  assign walkOn    = (st == ST_WALK);

endmodule

// File: rtl/hwySignalCtl.sv
module hwySignalCtl
  import sigPkg::*;
#(
  parameter int HOLD_CYC    = 6,
  parameter int SIDE_CYC    = 4,
  parameter int WALK_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sideCar,
  input  logic walkBtn,
  output logic hwyGreen,
  output logic hwyRed,
  output logic sideGreen,
  output logic sideRed,
  output logic walkOn
);

  strobe_t stb;
  logic    carSync;
  logic    walkReq;
  logic    timerZero;

  sigDatapath #(
    .HOLD_CYC(HOLD_CYC), .SIDE_CYC(SIDE_CYC),
    .WALK_CYC(WALK_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst(rst), .sideCar(sideCar), .walkBtn(walkBtn),
    .stb(stb), .carSync(carSync), .walkReq(walkReq), .timerZero(timerZero)
  );

  sigControl u_ctl (
    .clk(clk), .rst(rst), .carSync(carSync), .walkReq(walkReq),
    .timerZero(timerZero), .stb(stb),
    .hwyGreen(hwyGreen), .sideGreen(sideGreen), .walkOn(walkOn)
  );

  assign hwyRed  = !hwyGreen;
  assign sideRed = !sideGreen;

endmodule

// File: rtl/sigChk.sv
module sigChk #(
  parameter int HOLD_CYC = 6,
  parameter int SIDE_CYC = 4,
  parameter int WALK_CYC = 3
) (
  input logic clk,
  input logic rst,
  input logic hwyGreen,
  input logic hwyRed,
  input logic sideGreen,
  input logic sideRed,
  input logic walkOn
);

  logic [7:0] hwyRun, sideRun, walkRun;
  logic       prevSide;
  logic       vehSince;

  always_ff @(posedge clk) begin
    if (rst) begin
      hwyRun   <= '0;
      sideRun  <= '0;
      walkRun  <= '0;
      prevSide <= 1'b0;
      vehSince <= 1'b1;
    end else begin
      hwyRun   <= !hwyGreen  ? '0 : (hwyRun  == 8'hFF ? hwyRun  : hwyRun  + 1'b1);
      sideRun  <= !sideGreen ? '0 : (sideRun == 8'hFF ? sideRun : sideRun + 1'b1);
      walkRun  <= !walkOn    ? '0 : (walkRun == 8'hFF ? walkRun : walkRun + 1'b1);
      prevSide <= sideGreen;
      if (walkOn) vehSince <= 1'b0;
      else if ((prevSide && !sideGreen) || (hwyGreen && hwyRun >= 8'(HOLD_CYC - 1)))
        vehSince <= 1'b1;
    end
  end

  // R10
  one_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({hwyGreen, sideGreen, walkOn}));

  // R10
  red_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (hwyRed != hwyGreen) && (sideRed != sideGreen));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (hwyGreen && !sideGreen && !walkOn));

  // R3
  hwy_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hwyGreen) |-> (hwyRun >= 8'(HOLD_CYC)));

  // R4
  side_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sideGreen) |-> (sideRun == 8'(SIDE_CYC)));

  // R5
  walk_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(walkOn) |-> (walkRun == 8'(WALK_CYC)));

  // R9
  walk_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(walkOn) |-> vehSince);

endmodule

bind hwySignalCtl sigChk #(
  .HOLD_CYC(HOLD_CYC), .SIDE_CYC(SIDE_CYC), .WALK_CYC(WALK_CYC)
) u_chk (
  .clk(clk), .rst(rst), .hwyGreen(hwyGreen), .hwyRed(hwyRed),
  .sideGreen(sideGreen), .sideRed(sideRed), .walkOn(walkOn)
);

// File: tb/hwySignalCtl_bench.sv
module hwySignalCtl_bench;

  logic clk = 1'b0;
  logic rst, sideCar, walkBtn;
  logic hwyGreen, hwyRed, sideGreen, sideRed, walkOn;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  always #10 clk = !clk;

  hwySignalCtl u_hwySignalCtl (
    .clk(clk), .rst(rst), .sideCar(sideCar), .walkBtn(walkBtn),
    .hwyGreen(hwyGreen), .hwyRed(hwyRed), .sideGreen(sideGreen),
    .sideRed(sideRed), .walkOn(walkOn)
  );

  // reference model: 0 idle green, 1 hold green, 2 side green, 3 walk
  int mPh, mLeft;
  bit mC1, mC2, mB1, mB2, mReq, mLock;

  always @(posedge clk) begin
    bit cons, fin;
    if (rst) begin
      mPh = 0; mLeft = 0; mC1 = 0; mC2 = 0; mB1 = 0; mB2 = 0;
      mReq = 0; mLock = 0;
    end else begin
      cons = 0; fin = 0;
      case (mPh)
        0: if (mC2 || mReq) begin mPh = 1; mLeft = 5; end
        1: if (mLeft == 0) begin
             fin = 1;
             if (mReq) begin mPh = 3; mLeft = 2; cons = 1; end
             else if (mC2) begin mPh = 2; mLeft = 3; end
             else mPh = 0;
           end else mLeft--;
        2: if (mLeft == 0) begin fin = 1; mPh = 0; end else mLeft--;
        default: if (mLeft == 0) begin
             if (mC2) begin mPh = 2; mLeft = 3; end
             else begin mPh = 1; mLeft = 5; end
           end else mLeft--;
      endcase
      if (cons) mReq = 0;
      else if (mB2 && !mLock) mReq = 1;
      if (cons) mLock = 1;
      else if (fin) mLock = 0;
      mC2 = mC1; mC1 = sideCar;
      mB2 = mB1; mB1 = walkBtn;
    end
  end

  function automatic bit expHwy(int ph);  return ph <= 1; endfunction
  function automatic bit expSide(int ph); return ph == 2; endfunction
  function automatic bit expWalk(int ph); return ph == 3; endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance one cycle and compare with the model at the negedge
  task automatic step();
    @(negedge clk);
    if (!rst) begin
      chk($countones({hwyGreen, sideGreen, walkOn}) == 1 &&
          hwyRed == !hwyGreen && sideRed == !sideGreen,
          "R10 exclusive", {hwyGreen, sideGreen, walkOn}, 0);
      chk({hwyGreen, sideGreen, walkOn} ==
          {expHwy(mPh), expSide(mPh), expWalk(mPh)},
          "R9 model", {hwyGreen, sideGreen, walkOn},
          {expHwy(mPh), expSide(mPh), expWalk(mPh)});
    end
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, walks, sides;
    bit gapOk, vehSeen, wasWalk, wasSide;
    void'($urandom(32'd4242));
    rst = 1; sideCar = 0; walkBtn = 0;
    repeat (4) @(negedge clk);
    // R1
    chk(hwyGreen && !hwyRed && sideRed && !sideGreen && !walkOn, "R1 reset",
        {hwyGreen, sideGreen, walkOn}, 3'b100);
    rst = 0;
    step();
    chk(hwyGreen && !walkOn, "R1 after reset", hwyGreen, 1);

    // R2: no demand
    n = 0;
    for (int i = 0; i < 25; i++) begin step(); n += hwyGreen; end
    chk(n == 25, "R2 idle green", n, 25);

    // R3: sensor latency and hold
    sideCar = 1; n = 0;
    do begin step(); n++; end while (hwyGreen && n < 40);
    chk(n == 9, "R3 hold count", n, 9);
    // R4: side length
    sideCar = 0; n = 0;
    while (sideGreen && n < 40) begin n++; step(); end
    chk(n == 4, "R4 side length", n, 4);
    chk(hwyGreen, "R4 back to highway", hwyGreen, 1);
    settle(20);

    // R6 / R5: single-cycle press
    walkBtn = 1; n = 0;
    do begin step(); n++; walkBtn = 0; end while (hwyGreen && n < 40);
    chk(n == 10, "R6 pulse latched", n, 10);
    chk(walkOn && !sideGreen && hwyRed && sideRed, "R5 both red", walkOn, 1);
    n = 0;
    while (walkOn && n < 40) begin n++; step(); end
    chk(n == 3, "R5 walk length", n, 3);
    n = 0;
    for (int i = 0; i < 6; i++) begin n += hwyGreen; step(); end
    chk(n == 6, "R9 highway after walk", n, 6);
    settle(20);

    // R7: presses inside lockout are ignored
    walkBtn = 1; step(); walkBtn = 0;
    n = 0;
    while (!walkOn && n < 40) begin step(); n++; end
    walkBtn = 1; step(); walkBtn = 0;
    while (walkOn) step();
    walkBtn = 1; step(); walkBtn = 0;
    n = 0;
    for (int i = 0; i < 40; i++) begin step(); n += walkOn; end
    chk(n == 0, "R7 lockout ignores press", n, 0);
    chk(hwyGreen, "R7 highway idle", hwyGreen, 1);

    // R8: both pending, walk first then side
    sideCar = 1; walkBtn = 1; n = 0;
    do begin step(); n++; walkBtn = 0; end while (hwyGreen && n < 40);
    chk(n == 9 && walkOn, "R8 walk first", n, 9);
    settle(3);
    chk(sideGreen, "R8 side follows walk", sideGreen, 1);
    sideCar = 0;
    settle(30);

    // R9: held button and sensor
    sideCar = 1; walkBtn = 1;
    walks = 0; sides = 0; gapOk = 1; vehSeen = 1; wasWalk = 0; wasSide = 0;
    for (int i = 0; i < 120; i++) begin
      step();
      if (walkOn && !wasWalk) begin
        if (!vehSeen) gapOk = 0;
        vehSeen = 0; walks++;
      end
      if (!sideGreen && wasSide) begin vehSeen = 1; sides++; end
      wasWalk = walkOn; wasSide = sideGreen;
    end
    chk(gapOk, "R9 no back-to-back walk", gapOk, 1);
    chk(walks >= 3 && sides >= 3, "R9 alternation", walks, 3);
    sideCar = 0; walkBtn = 0;
    settle(30);

    // reset mid-phase returns to idle green
    sideCar = 1; settle(10); rst = 1; sideCar = 0; step(); step();
    chk(hwyGreen && !sideGreen && !walkOn, "R1 reset mid-phase",
        {hwyGreen, sideGreen, walkOn}, 3'b100);
    rst = 0; settle(5);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(7) == 0) sideCar = !sideCar;
      walkBtn = ($urandom_range(11) == 0);
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule